// File: doc/BRIEF.md
# SDRAM Control Register and Power-Up Sequencer

This block sits between an on-chip bus and an SDRAM. A single 16-bit control/status register holds its configuration. Software uses it to pick how many column bits the device has, which two internal address bits form the bank number, whether read data is registered, whether the memory clock is inverted, whether the memory should sleep, and whether a power-up initialization should run. From that configuration the block splits each flat internal address into column, row and bank fields. It also flags the extra read wait state that registered read data costs.

An initialization that has been armed does not start by itself. The first write access to memory space after arming launches the sequence: precharge-all, two auto-refresh commands and a mode-register set, with a fixed idle gap between commands. The ACT status bit then goes high. Requesting sleep sends a self-refresh entry and drops clock enable. Clearing the request sends a self-refresh exit and waits a fixed recovery time before memory accesses are accepted again.

Top module: `sdr_ctl_front`

## Requirements
- R1: After reset the register reads 0x0000. Its layout is: [1:0] column select, [4:2] bank location, [5] sleep request, [6] read-register, [7] clock invert, [8] init enable, [14] ACT (read-only), [15] SLEEP (read-only). Bits [13:9] always read zero, and writes to bits 14 and 15 have no effect.
- R2: With column select s, the column msb is A(7+s). col_addr bit i equals address bit i+2 for i+2 <= 7+s, and is zero otherwise. row_addr equals the address shifted right by 8+s, truncated to ROW_W bits.
- R3: With bank location c in 1..5, bank_addr = {A(20+c), A(19+c)}. For the reserved codes 0, 6 and 7, bank_addr is 0.
- R4: Commands are encoded as 0 NOP, 1 precharge-all, 2 auto-refresh, 3 mode set, 4 self-refresh entry and 5 self-refresh exit. A write with init enable set arms the sequencer. Arming takes effect only from the unconfigured or ready state. The first write access after arming, sampled at edge n, produces precharge-all at edge n+2. Auto-refresh, auto-refresh and mode set follow, each GAP_CYC+1 cycles after the previous command.
- R5: ACT rises GAP_CYC cycles after the mode set command. Any register write clears ACT.
- R6: cfg_err is high while the bank location is reserved, or while read-register and clock invert are both 1. A write that sets init enable together with such a configuration does not arm, and the state is unchanged.
- R7: With the block ready, setting sleep request issues self-refresh entry on the edge after the write. SLEEP goes high and sd_cke goes low at that edge. Clearing the request issues self-refresh exit on the edge after the write, and sd_cke goes high again. SLEEP clears and accesses are accepted REC_CYC+1 cycles after the exit command.
- R8: rd_extra_wait is 1 only for a valid read with read-register set that is a single read or the first word of a burst (acc_beat = 0). Later burst words and writes get 0.
- R9: sd_clk_inv equals clock invert while read-register is 0. It is forced to 0 when read-register is 1.
- R10: acc_ok is 1 only when the sequencer is ready. It is 0 while unconfigured, armed, initializing, sleeping or recovering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register and status read data |
| acc_valid | input | 1 | Memory access present |
| acc_write | input | 1 | Access is a write |
| acc_beat | input | 1 | Access is a later word of a burst |
| acc_addr | input | ADDR_W | Flat internal byte address |
| acc_ok | output | 1 | Accesses accepted |
| rd_extra_wait | output | 1 | Add one read wait state |
| row_addr | output | ROW_W | Row address |
| col_addr | output | 9 | Column address |
| bank_addr | output | 2 | Bank address |
| sd_cmd | output | 3 | Registered SDRAM command |
| sd_cke | output | 1 | Clock enable |
| sd_clk_inv | output | 1 | Invert memory clock |
| cfg_err | output | 1 | Configuration invalid |

## Verification
The address split, rd_extra_wait, cfg_err and sd_clk_inv are combinational, so the bench compares them in the same cycle, one time step after it drives the input. Register contents are checked one edge after the write. Commands are due two edges after the triggering access or write: one edge for the state change and one for the command register. The scoreboard therefore files each expected command with that exact cycle number and compares the cycle at which it appears. ACT and acc_ok are sampled one cycle before and in the cycle GAP_CYC after mode set. SLEEP is sampled in the cycle REC_CYC after the exit command and again one cycle later.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    localparam int REG_W         = 16;
    localparam int ACT_BIT       = 14;
    localparam int SLEEP_BIT     = 15;
    localparam int COL_LSB       = 2;
    localparam int COL_MSB_BASE  = 7;
    localparam int COL_SEL_MAX   = 3;
    localparam int COL_W         = COL_MSB_BASE + COL_SEL_MAX - COL_LSB + 1;
    localparam int BANK_BASE     = 19;
    localparam int BANK_CODES    = 5;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_PALL = 3'd1,
        CMD_AREF = 3'd2,
        CMD_MRS  = 3'd3,
        CMD_SRE  = 3'd4,
        CMD_SRX  = 3'd5
    } sdc_cmd_e;

    typedef enum logic [3:0] {
        SQ_OFF,
        SQ_ARMED,
        SQ_PALL,
        SQ_REF1,
        SQ_REF2,
        SQ_MRS,
        SQ_READY,
        SQ_SLEEP,
        SQ_WAKE
    } sdc_state_e;

    typedef struct packed {
        logic       init_en;
        logic       clk_inv;
        logic       rd_reg;
        logic       sleep_req;
        logic [2:0] bank_loc;
        logic [1:0] col_sel;
    } sdc_cfg_t;

    localparam int CFG_W = $bits(sdc_cfg_t);

    function automatic logic bank_code_ok(input logic [2:0] code);
        return (code >= 3'd1) && (code <= 3'(BANK_CODES));
    endfunction

    function automatic logic cfg_bad(input sdc_cfg_t c);
        return !bank_code_ok(c.bank_loc) || (c.rd_reg && c.clk_inv);
    endfunction

    function automatic logic [4:0] col_msb(input logic [1:0] sel);
        return 5'(COL_MSB_BASE) + {3'b000, sel};
    endfunction

    function automatic sdc_cmd_e init_cmd(input sdc_state_e s);
        case (s)
            SQ_PALL: return CMD_PALL;
            SQ_REF1: return CMD_AREF;
            SQ_REF2: return CMD_AREF;
            SQ_MRS:  return CMD_MRS;
            default: return CMD_NOP;
        endcase
    endfunction

    function automatic sdc_state_e init_next(input sdc_state_e s);
        case (s)
            SQ_PALL: return SQ_REF1;
            SQ_REF1: return SQ_REF2;
            SQ_REF2: return SQ_MRS;
            default: return SQ_READY;
        endcase
    endfunction

endpackage

// File: rtl/sdc_cfg_reg.sv
module sdc_cfg_reg
    import sdc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             act_set,
    input  logic             sleep_st,
    output sdc_cfg_t         cfg,
    output logic             act,
    output logic [REG_W-1:0] rdata,
    output logic             cfg_err,
    output logic             arm
);

    sdc_cfg_t new_cfg;
    logic     wdata_unused;

    assign new_cfg      = sdc_cfg_t'(wdata[CFG_W-1:0]);
    assign wdata_unused = ^wdata[REG_W-1:CFG_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
            act <= 1'b0;
        end else begin
            if (wr) begin
                cfg <= new_cfg;
            end
            // a write always wins over completion
            if (wr) begin
                act <= 1'b0;
            end else if (act_set) begin
                act <= 1'b1;
            end
        end
    end

    assign cfg_err = cfg_bad(cfg);
    assign arm     = wr && new_cfg.init_en && !cfg_bad(new_cfg);

    always_comb begin
        rdata              = '0;
        rdata[CFG_W-1:0]   = cfg;
        rdata[ACT_BIT]     = act;
        rdata[SLEEP_BIT]   = sleep_st;
    end

endmodule

// File: rtl/sdc_addr_split.sv
module sdc_addr_split
    import sdc_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int ROW_W  = 13
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        col_sel,
    input  logic [2:0]        bank_loc,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col,
    output logic [1:0]        bank
);

    logic [4:0]        msb;
    logic [ADDR_W-1:0] shifted;
    logic [1:0]        cand [BANK_CODES];

    assign msb = col_msb(col_sel);

    for (genvar i = 0; i < COL_W; i++) begin : g_col
        assign col[i] = (5'(i + COL_LSB) <= msb) ? addr[i + COL_LSB] : 1'b0;
    end

    assign shifted = addr >> (msb + 5'd1);
    assign row     = shifted[ROW_W-1:0];

    for (genvar k = 0; k < BANK_CODES; k++) begin : g_bank
        assign cand[k] = {addr[BANK_BASE + k + 2], addr[BANK_BASE + k + 1]};
    end

    always_comb begin
        bank = 2'b00;
        if (bank_code_ok(bank_loc)) begin
            bank = cand[3'(bank_loc - 3'd1)];
        end
    end

endmodule

// File: rtl/sdc_seq.sv
module sdc_seq
    import sdc_pkg::*;
#(
    parameter int GAP_CYC = 3,
    parameter int REC_CYC = 5
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     arm,
    input  logic     acc_valid,
    input  logic     acc_write,
    input  logic     sleep_req,
    output sdc_cmd_e cmd,
    output logic     act_set,
    output logic     ready,
    output logic     sleeping,
    output logic     cke
);

    localparam int MAX_CNT = (GAP_CYC > REC_CYC) ? GAP_CYC : REC_CYC;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);

    sdc_state_e       state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    sdc_cmd_e         cmd_n;

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        cmd_n   = CMD_NOP;
        act_set = 1'b0;
        case (state)
            SQ_OFF: begin
                if (arm) state_n = SQ_ARMED;
            end
            SQ_ARMED: begin
                if (acc_valid && acc_write) begin
                    state_n = SQ_PALL;
                    cnt_n   = '0;
                end
            end
            SQ_PALL, SQ_REF1, SQ_REF2, SQ_MRS: begin
                if (cnt == '0) cmd_n = init_cmd(state);
                if (cnt == CNT_W'(GAP_CYC)) begin
                    state_n = init_next(state);
                    cnt_n   = '0;
                    act_set = (state == SQ_MRS);
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            SQ_READY: begin
                if (arm) begin
                    state_n = SQ_ARMED;
                end else if (sleep_req) begin
                    state_n = SQ_SLEEP;
                    cmd_n   = CMD_SRE;
                end
            end
            SQ_SLEEP: begin
                if (!sleep_req) begin
                    state_n = SQ_WAKE;
                    cnt_n   = '0;
                    cmd_n   = CMD_SRX;
                end
            end
            SQ_WAKE: begin
                if (cnt == CNT_W'(REC_CYC)) begin
                    state_n = SQ_READY;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            default: state_n = SQ_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_OFF;
            cnt   <= '0;
            cmd   <= CMD_NOP;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            cmd   <= cmd_n;
        end
    end

    assign ready    = (state == SQ_READY);
    assign sleeping = (state == SQ_SLEEP) || (state == SQ_WAKE);
    assign cke      = (state != SQ_SLEEP);

endmodule

// File: rtl/sdr_ctl_front.sv
module sdr_ctl_front
    import sdc_pkg::*;
#(
    parameter int ADDR_W  = 26,
    parameter int ROW_W   = 13,
    parameter int GAP_CYC = 3,
    parameter int REC_CYC = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_beat,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              acc_ok,
    output logic              rd_extra_wait,
    output logic [ROW_W-1:0]  row_addr,
    output logic [COL_W-1:0]  col_addr,
    output logic [1:0]        bank_addr,
    output logic [2:0]        sd_cmd,
    output logic              sd_cke,
    output logic              sd_clk_inv,
    output logic              cfg_err
);

    sdc_cfg_t cfg;
    sdc_cmd_e cmd;
    logic     act, act_set, arm, sleeping;

    sdc_cfg_reg u_reg (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .wdata    (reg_wdata),
        .act_set  (act_set),
        .sleep_st (sleeping),
        .cfg      (cfg),
        .act      (act),
        .rdata    (reg_rdata),
        .cfg_err  (cfg_err),
        .arm      (arm)
    );

    sdc_addr_split #(
        .ADDR_W (ADDR_W),
        .ROW_W  (ROW_W)
    ) u_split (
        .addr     (acc_addr),
        .col_sel  (cfg.col_sel),
        .bank_loc (cfg.bank_loc),
        .row      (row_addr),
        .col      (col_addr),
        .bank     (bank_addr)
    );

    sdc_seq #(
        .GAP_CYC (GAP_CYC),
        .REC_CYC (REC_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .arm       (arm),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .sleep_req (cfg.sleep_req),
        .cmd       (cmd),
        .act_set   (act_set),
        .ready     (acc_ok),
        .sleeping  (sleeping),
        .cke       (sd_cke)
    );

    assign sd_cmd        = cmd;
    assign sd_clk_inv    = cfg.clk_inv && !cfg.rd_reg;
    assign rd_extra_wait = cfg.rd_reg && acc_valid && !acc_write && !acc_beat;

endmodule

// File: rtl/sdr_ctl_front_chk.sv
module sdr_ctl_front_chk
    import sdc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic [REG_W-1:0] reg_rdata,
    input logic             acc_valid,
    input logic             acc_write,
    input logic             acc_beat,
    input logic             acc_ok,
    input logic             rd_extra_wait,
    input logic [2:0]       sd_cmd,
    input logic             sd_cke,
    input logic             sd_clk_inv
);

    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[ACT_BIT-1:CFG_W] == '0);

    p_cmd_spaced_r4: assert property (@(posedge clk) disable iff (rst)
        (sd_cmd == 3'd1 || sd_cmd == 3'd2 || sd_cmd == 3'd3) |=> sd_cmd == 3'd0);

    p_act_clear_r5: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> !reg_rdata[ACT_BIT]);

    p_cke_sleep_r7: assert property (@(posedge clk) disable iff (rst)
        !sd_cke |-> reg_rdata[SLEEP_BIT]);

    p_sleep_entry_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(reg_rdata[SLEEP_BIT]) |-> sd_cmd == 3'd4);

    p_burst_nowait_r8: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && acc_beat) |-> !rd_extra_wait);

    p_clkinv_r9: assert property (@(posedge clk) disable iff (rst)
        sd_clk_inv |-> !reg_rdata[6]);

    p_busy_r10: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[SLEEP_BIT] |-> !acc_ok);

endmodule

bind sdr_ctl_front sdr_ctl_front_chk u_chk (.*);

// File: tb/test_sdr_ctl_front.sv
module test_sdr_ctl_front;

    localparam int ADDR_W = 26;
    localparam int ROW_W  = 13;
    localparam int COL_W  = 9;
    localparam int G      = 3;
    localparam int REC    = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_wr = 1'b0;
    logic [15:0]       reg_wdata = '0;
    logic [15:0]       reg_rdata;
    logic              acc_valid = 1'b0;
    logic              acc_write = 1'b0;
    logic              acc_beat = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic              acc_ok;
    logic              rd_extra_wait;
    logic [ROW_W-1:0]  row_addr;
    logic [COL_W-1:0]  col_addr;
    logic [1:0]        bank_addr;
    logic [2:0]        sd_cmd;
    logic              sd_cke;
    logic              sd_clk_inv;
    logic              cfg_err;

    always #4 clk = ~clk;

    sdr_ctl_front #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .GAP_CYC(G), .REC_CYC(REC))
        i_sdr_ctl_front (.*);

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    int    q_cmd[$];
    int    q_cyc[$];
    string q_req[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !done && sd_cmd != 3'd0) begin
            if (q_cmd.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R4 unexpected command: actual=%0d expected=none", sd_cmd);
            end else begin
                automatic int    c = q_cmd.pop_front();
                automatic int    y = q_cyc.pop_front();
                automatic string r = q_req.pop_front();
                chk(r, "command", 32'(sd_cmd), 32'(c));
                chk(r, "command cycle", 32'(cyc), 32'(y));
            end
        end
    end

    task automatic expect_cmd(input int c, input int at, input string req);
        q_cmd.push_back(c);
        q_cyc.push_back(at);
        q_req.push_back(req);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [15:0] wd);
        reg_wr    = 1'b1;
        reg_wdata = wd;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic dummy_write();
        acc_valid = 1'b1;
        acc_write = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
        acc_write = 1'b0;
    endtask

    function automatic logic [COL_W-1:0] exp_col(input logic [ADDR_W-1:0] a, input int sel);
        logic [COL_W-1:0] r = '0;
        for (int i = 0; i < COL_W; i++)
            if (i + 2 <= 7 + sel) r[i] = a[i + 2];
        return r;
    endfunction

    function automatic logic [ROW_W-1:0] exp_row(input logic [ADDR_W-1:0] a, input int sel);
        logic [ADDR_W-1:0] s = a >> (8 + sel);
        return s[ROW_W-1:0];
    endfunction

    function automatic logic [1:0] exp_bank(input logic [ADDR_W-1:0] a, input int code);
        if (code >= 1 && code <= 5) return {a[20 + code], a[19 + code]};
        return 2'b00;
    endfunction

    task automatic do_init(input logic [15:0] cfgw);
        int n;
        int m;
        reg_write(cfgw | 16'h0100);
        chk("R10", "acc_ok while armed", 32'(acc_ok), 0);
        idle(6);
        chk("R4", "no start before dummy write", 32'(q_cmd.size()), 0);
        n = cyc;
        dummy_write();
        expect_cmd(1, n + 2, "R4");
        expect_cmd(2, n + 2 + (G + 1), "R4");
        expect_cmd(2, n + 2 + 2 * (G + 1), "R4");
        expect_cmd(3, n + 2 + 3 * (G + 1), "R4");
        m = n + 2 + 3 * (G + 1);
        while (cyc < m + G - 1) @(negedge clk);
        chk("R5", "ACT before done", 32'(reg_rdata[14]), 0);
        chk("R10", "acc_ok during init", 32'(acc_ok), 0);
        @(negedge clk);
        chk("R5", "ACT after mode set", 32'(reg_rdata[14]), 1);
        chk("R10", "acc_ok after init", 32'(acc_ok), 1);
        chk("R4", "all init commands seen", 32'(q_cmd.size()), 0);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        chk("R1", "reset rdata", 32'(reg_rdata), 0);
        chk("R1", "reset cmd", 32'(sd_cmd), 0);
        chk("R1", "reset cke", 32'(sd_cke), 1);
        chk("R10", "reset acc_ok", 32'(acc_ok), 0);

        // R1 reserved/read-only bits; R6 bad config withholds init
        reg_write(16'hFFFF);
        chk("R1", "all-ones readback", 32'(reg_rdata), 32'h01FF);
        chk("R6", "cfg_err bad config", 32'(cfg_err), 1);
        chk("R9", "clk_inv forced low", 32'(sd_clk_inv), 0);
        dummy_write();
        idle(8);
        chk("R6", "no init after bad arm", 32'(acc_ok), 0);

        // R2 R3 address split
        for (int sel = 0; sel < 4; sel++) begin
            for (int ai = 0; ai < 3; ai++) begin
                automatic int code = (sel * 3 + ai) % 8;
                automatic logic [ADDR_W-1:0] a =
                    (ai == 0) ? 26'h2A5C3B7 : (ai == 1) ? 26'h1234567 : 26'h3FFFFFF;
                reg_write(16'((code << 2) | sel));
                acc_addr = a;
                #1;
                chk("R2", "column", 32'(col_addr), 32'(exp_col(a, sel)));
                chk("R2", "row", 32'(row_addr), 32'(exp_row(a, sel)));
                chk("R3", "bank", 32'(bank_addr), 32'(exp_bank(a, code)));
                chk("R6", "cfg_err by bank code", 32'(cfg_err),
                    32'((code == 0 || code > 5) ? 1 : 0));
            end
        end

        do_init(16'h0006);

        // R8 read wait state
        reg_write(16'h0046);
        chk("R5", "write clears ACT", 32'(reg_rdata[14]), 0);
        chk("R10", "still ready", 32'(acc_ok), 1);
        acc_valid = 1'b1; acc_write = 1'b0; acc_beat = 1'b0; #1;
        chk("R8", "single read wait", 32'(rd_extra_wait), 1);
        acc_beat = 1'b1; #1;
        chk("R8", "later burst word", 32'(rd_extra_wait), 0);
        acc_write = 1'b1; acc_beat = 1'b0; #1;
        chk("R8", "write no wait", 32'(rd_extra_wait), 0);
        acc_valid = 1'b0; acc_write = 1'b0;
        @(negedge clk);
        reg_write(16'h0006);
        acc_valid = 1'b1; #1;
        chk("R8", "read without registering", 32'(rd_extra_wait), 0);
        acc_valid = 1'b0;
        @(negedge clk);

        // R9 clock invert
        reg_write(16'h0086);
        chk("R9", "clock invert", 32'(sd_clk_inv), 1);
        chk("R6", "valid inv config", 32'(cfg_err), 0);
        reg_write(16'h00C6);
        chk("R9", "invert with rd_reg", 32'(sd_clk_inv), 0);
        chk("R6", "invalid combo flagged", 32'(cfg_err), 1);

        // R6 arming withheld from ready state
        reg_write(16'h01C6);
        idle(8);
        chk("R6", "no rearm invalid combo", 32'(acc_ok), 1);
        reg_write(16'h011A);
        chk("R6", "reserved bank flagged", 32'(cfg_err), 1);
        idle(8);
        chk("R6", "no rearm reserved bank", 32'(acc_ok), 1);
        reg_write(16'h0006);

        // R7 sleep entry and exit
        reg_write(16'h0026);
        expect_cmd(4, cyc + 1, "R7");
        @(negedge clk);
        chk("R7", "SLEEP set", 32'(reg_rdata[15]), 1);
        chk("R7", "cke low", 32'(sd_cke), 0);
        chk("R10", "no access in sleep", 32'(acc_ok), 0);
        dummy_write();
        idle(3);
        begin
            int t;
            reg_write(16'h0006);
            expect_cmd(5, cyc + 1, "R7");
            t = cyc + 1 + REC;
            @(negedge clk);
            chk("R7", "cke high after exit", 32'(sd_cke), 1);
            while (cyc < t) @(negedge clk);
            chk("R7", "SLEEP during recovery", 32'(reg_rdata[15]), 1);
            chk("R10", "no access in recovery", 32'(acc_ok), 0);
            @(negedge clk);
            chk("R7", "SLEEP cleared", 32'(reg_rdata[15]), 0);
            chk("R10", "ready after recovery", 32'(acc_ok), 1);
        end

        // R4 re-initialization from ready
        do_init(16'h0006);

        idle(4);
        chk("R4", "scoreboard drained", 32'(q_cmd.size()), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R4 watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule